// File: doc/BRIEF.md
# Atomic Memory Exchange Engine

This block runs one indivisible read-modify-write on a single-port memory. A caller presents an operation code, a word address, a register operand and an accumulator operand. The engine reads the addressed word, works out the new memory value and the new register and accumulator values, and writes the word back. A lock output stays high from the read request until the write is acknowledged, so an arbiter outside the block can keep other masters off the memory for the whole sequence.

Four operations are supported. Swap and fetch-add work on the low 32 bits of the 64-bit memory word. A 32-bit compare-swap also works on the low 32 bits. A wide compare-swap works on the full 64-bit word, with each operand treated as a high:low register pair. For 32-bit operations the upper half of the memory word is written back unchanged, and the upper halves of both operands pass through to the results unchanged. Every sequence ends with a write, even when a compare fails.

Requests use a valid/ready handshake. A request is taken on a clock edge where both `req_valid` and `req_ready` are high. The caller must hold the request fields steady while `req_valid` is high and `req_ready` is low. `req_ready` is low for the whole sequence, so a waiting request is simply held back until the engine returns to idle. Results are given on plain outputs, qualified by a one-cycle `done` pulse.

Top module: `atx_engine`

## Requirements
- R1: After reset, `req_ready` is high and `busy`, `mem_lock`, `mem_req` and `done` are low. `req_ready` is high exactly when the engine is idle, and `busy` is its inverse.
- R2: An accepted request gives exactly one read and then exactly one write, both to the request address. The read request (`mem_req`=1, `mem_we`=0) starts in the cycle after acceptance. The write request (`mem_we`=1) starts in the cycle after `mem_rvalid`. Each request holds its address and direction until `mem_ack`.
- R3: `mem_lock` is high from the first read-request cycle through the cycle in which the write is acknowledged. It is low at every other time, including the `done` cycle.
- R4: `done` is a one-cycle pulse in the cycle after the write acknowledge. `res_reg`, `res_acc` and `res_flags` are valid while `done` is high. The flags field is packed as bit0 carry, bit1 parity (set when the low result byte has an even number of ones), bit2 zero, bit3 sign, bit4 signed overflow.
- R5: Swap (op code 0) writes the register's low half into the memory low half. `res_reg` returns the old memory low half, `res_acc` equals the accumulator, and the flags are all zero.
- R6: Fetch-add (op code 1) writes the 32-bit sum of the memory low half and the register low half, and `res_reg` returns the old memory low half. The flags describe that addition: the carry out of bit 31, whether the sum is zero, sum bit 31, signed overflow, and the parity of the sum's low byte.
- R7: Compare-swap (op code 2) with the accumulator low half equal to the memory low half writes the register low half into memory. `res_acc` and `res_reg` equal their operands.
- R8: Compare-swap (op code 2) on a mismatch writes the memory word back unchanged. `res_acc` becomes the accumulator high half joined to the memory low half.
- R9: The compare-swap flags are those of accumulator-low minus memory-low: the carry flag is the unsigned borrow, the zero flag marks success, and the sign, overflow and parity flags follow the difference.
- R10: Wide compare-swap (op code 3) compares the 64-bit accumulator with the 64-bit memory word. On a match it writes the 64-bit register. On a mismatch it writes the word back and returns it in `res_acc`. In both cases the zero flag equals the match and all other flags are zero.
- R11: The upper 32 bits of the memory word are preserved by every 32-bit operation. The upper halves of the register and the accumulator pass through unchanged to the results.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Engine idle and able to take a request |
| req_op | input | 2 | 0 swap, 1 fetch-add, 2 compare-swap, 3 wide compare-swap |
| req_addr | input | AW | Word address |
| req_reg | input | DW | Register operand (high:low pair) |
| req_acc | input | DW | Accumulator operand (high:low pair) |
| busy | output | 1 | A sequence is in progress |
| mem_req | output | 1 | Memory access request, held until acknowledged |
| mem_we | output | 1 | Access is a write |
| mem_addr | output | AW | Memory address |
| mem_wdata | output | DW | Write data |
| mem_ack | input | 1 | Memory accepts the current request |
| mem_rvalid | input | 1 | Read data valid, at least one cycle after the read acknowledge |
| mem_rdata | input | DW | Read data |
| mem_lock | output | 1 | Memory must stay reserved for this engine |
| done | output | 1 | One-cycle completion pulse |
| res_reg | output | DW | Updated register value |
| res_acc | output | DW | Updated accumulator value |
| res_flags | output | 5 | Status flags, packed as listed in R4 |

## Verification
A request taken at clock edge N puts a read request on the memory port just after N. The write request follows in the cycle after `mem_rvalid`, and `done`, valid results and the drop of `mem_lock` all appear in the cycle after the write acknowledge. The bench drives every input 2 ns after a rising edge and samples every output on the falling edge. A behavioural phase model advances once per falling edge from the handshakes it sees, and it predicts `req_ready`, `busy`, `mem_req`, `mem_we`, `mem_lock` and `done` for that exact cycle. The expected write word is computed when the read handshake is seen and compared at the write handshake. The expected results are compared on the falling edge where `done` is high, with memory latencies varied between runs.

// File: rtl/atx_pkg.sv
package atx_pkg;

  typedef enum logic [1:0] {
    OP_SWAP     = 2'd0,
    OP_FADD     = 2'd1,
    OP_CAS      = 2'd2,
    OP_CAS_WIDE = 2'd3
  } atx_op_e;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_READ  = 3'd1,
    ST_WAIT  = 3'd2,
    ST_WRITE = 3'd3,
    ST_DONE  = 3'd4
  } atx_state_e;

  // packed MSB first: bit4 of, bit3 sf, bit2 zf, bit1 pf, bit0 cf
  typedef struct packed {
    logic of;
    logic sf;
    logic zf;
    logic pf;
    logic cf;
  } atx_flags_t;

  localparam int FLAG_W = 5;

endpackage

// File: rtl/atx_flagcalc.sv
module atx_flagcalc #(
  parameter int W = 32
) (
  input  logic [W-1:0]        a,
  input  logic [W-1:0]        b,
  input  logic                sub,
  output logic [W-1:0]        result,
  output atx_pkg::atx_flags_t flags
);
  logic [W:0] ext;
  logic       sign_a, sign_b, sign_r;

  always_comb begin
    if (sub) ext = {1'b0, a} - {1'b0, b};
    else     ext = {1'b0, a} + {1'b0, b};
    result = ext[W-1:0];
    sign_a = a[W-1];
    sign_b = b[W-1];
    sign_r = ext[W-1];
    flags.cf = ext[W];
    flags.zf = (ext[W-1:0] == '0);
    flags.sf = sign_r;
    flags.pf = ~^ext[7:0];
    if (sub) flags.of = (sign_a != sign_b) && (sign_r != sign_a);
    else     flags.of = (sign_a == sign_b) && (sign_r != sign_a);
  end
endmodule

// File: rtl/atx_datapath.sv
module atx_datapath #(
  parameter int DW = 64
) (
  input  atx_pkg::atx_op_e    op,
  input  logic [DW-1:0]       reg_op,
  input  logic [DW-1:0]       acc_op,
  input  logic [DW-1:0]       mem_word,
  output logic [DW-1:0]       wdata,
  output logic [DW-1:0]       res_reg,
  output logic [DW-1:0]       res_acc,
  output atx_pkg::atx_flags_t flags
);
  import atx_pkg::*;
  localparam int HW = DW / 2;

  logic [HW-1:0] mem_hi, mem_lo, reg_hi, reg_lo, acc_hi, acc_lo;
  logic [HW-1:0] alu_a, alu_b, alu_res;
  logic          alu_sub, wide_hit;
  atx_flags_t    alu_flags, wide_flags;

  assign {mem_hi, mem_lo} = mem_word;
  assign {reg_hi, reg_lo} = reg_op;
  assign {acc_hi, acc_lo} = acc_op;

  // one shared adder: sum for fetch-add, acc - mem for the compares
  assign alu_sub = (op != OP_FADD);
  assign alu_a   = alu_sub ? acc_lo : mem_lo;
  assign alu_b   = alu_sub ? mem_lo : reg_lo;

  atx_flagcalc #(.W(HW)) u_alu (
    .a      (alu_a),
    .b      (alu_b),
    .sub    (alu_sub),
    .result (alu_res),
    .flags  (alu_flags)
  );

  assign wide_hit   = (acc_op == mem_word);
  assign wide_flags = '{of: 1'b0, sf: 1'b0, zf: wide_hit, pf: 1'b0, cf: 1'b0};

  always_comb begin
    wdata   = mem_word;
    res_reg = reg_op;
    res_acc = acc_op;
    flags   = '0;
    unique case (op)
      OP_SWAP: begin
        wdata   = {mem_hi, reg_lo};
        res_reg = {reg_hi, mem_lo};
      end
      OP_FADD: begin
        wdata   = {mem_hi, alu_res};
        res_reg = {reg_hi, mem_lo};
        flags   = alu_flags;
      end
      OP_CAS: begin
        flags = alu_flags;
        if (alu_flags.zf) wdata   = {mem_hi, reg_lo};
        else              res_acc = {acc_hi, mem_lo};
      end
      OP_CAS_WIDE: begin
        flags = wide_flags;
        if (wide_hit) wdata   = reg_op;
        else          res_acc = mem_word;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/atx_seq.sv
module atx_seq (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic mem_ack,
  input  logic mem_rvalid,
  output logic idle,
  output logic mem_req,
  output logic mem_we,
  output logic lock,
  output logic done,
  output logic take_rdata
);
  import atx_pkg::*;
  atx_state_e state, state_nx;

  always_comb begin
    state_nx = state;
    unique case (state)
      ST_IDLE:  if (start)      state_nx = ST_READ;
      ST_READ:  if (mem_ack)    state_nx = ST_WAIT;
      ST_WAIT:  if (mem_rvalid) state_nx = ST_WRITE;
      ST_WRITE: if (mem_ack)    state_nx = ST_DONE;
      ST_DONE:                  state_nx = ST_IDLE;
      default:                  state_nx = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= ST_IDLE;
    else        state <= state_nx;
  end

  assign idle       = (state == ST_IDLE);
  assign mem_req    = (state == ST_READ) || (state == ST_WRITE);
  assign mem_we     = (state == ST_WRITE);
  assign lock       = (state == ST_READ) || (state == ST_WAIT) || (state == ST_WRITE);
  assign done       = (state == ST_DONE);
  assign take_rdata = (state == ST_WAIT) && mem_rvalid;
endmodule

// File: rtl/atx_engine.sv
module atx_engine #(
  parameter int AW = 16,
  parameter int DW = 64
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic [1:0]    req_op,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_reg,
  input  logic [DW-1:0] req_acc,
  output logic          busy,
  output logic          mem_req,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  input  logic          mem_ack,
  input  logic          mem_rvalid,
  input  logic [DW-1:0] mem_rdata,
  output logic          mem_lock,
  output logic          done,
  output logic [DW-1:0] res_reg,
  output logic [DW-1:0] res_acc,
  output logic [4:0]    res_flags
);
  import atx_pkg::*;

  logic          idle, start, take_rdata;
  atx_op_e       op_q;
  logic [AW-1:0] addr_q;
  logic [DW-1:0] reg_q, acc_q, rdata_q;
  atx_flags_t    flags_w;

  assign start     = req_valid && idle;
  assign req_ready = idle;
  assign busy      = !idle;

  atx_seq u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .mem_ack    (mem_ack),
    .mem_rvalid (mem_rvalid),
    .idle       (idle),
    .mem_req    (mem_req),
    .mem_we     (mem_we),
    .lock       (mem_lock),
    .done       (done),
    .take_rdata (take_rdata)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      op_q    <= OP_SWAP;
      addr_q  <= '0;
      reg_q   <= '0;
      acc_q   <= '0;
      rdata_q <= '0;
    end else begin
      if (start) begin
        op_q   <= atx_op_e'(req_op);
        addr_q <= req_addr;
        reg_q  <= req_reg;
        acc_q  <= req_acc;
      end
      if (take_rdata) rdata_q <= mem_rdata;
    end
  end

  assign mem_addr = addr_q;

  atx_datapath #(.DW(DW)) u_dp (
    .op       (op_q),
    .reg_op   (reg_q),
    .acc_op   (acc_q),
    .mem_word (rdata_q),
    .wdata    (mem_wdata),
    .res_reg  (res_reg),
    .res_acc  (res_acc),
    .flags    (flags_w)
  );

  assign res_flags = flags_w;
endmodule

// File: rtl/atx_engine_chk.sv
module atx_engine_chk #(
  parameter int AW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          req_valid,
  input logic          req_ready,
  input logic          busy,
  input logic          mem_req,
  input logic          mem_we,
  input logic [AW-1:0] mem_addr,
  input logic          mem_ack,
  input logic          mem_rvalid,
  input logic          mem_lock,
  input logic          done
);
  p_busy_not_ready_r1: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !req_ready);

  p_accept_reads_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> (mem_req && !mem_we && mem_lock));

  p_req_held_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));

  p_data_then_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rvalid && mem_lock && !mem_req) |=> (mem_req && mem_we));

  p_req_locked_r3: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> mem_lock);

  p_lock_blocks_ready_r3: assert property (@(posedge clk) disable iff (!rst_n)
    mem_lock |-> !req_ready);

  p_release_on_wack_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_we && mem_ack) |=> (!mem_lock && done));

  p_done_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_done_follows_write_r4: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(mem_req && mem_we && mem_ack));
endmodule

bind atx_engine atx_engine_chk #(.AW(AW)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .req_valid  (req_valid),
  .req_ready  (req_ready),
  .busy       (busy),
  .mem_req    (mem_req),
  .mem_we     (mem_we),
  .mem_addr   (mem_addr),
  .mem_ack    (mem_ack),
  .mem_rvalid (mem_rvalid),
  .mem_lock   (mem_lock),
  .done       (done)
);

// File: tb/atx_engine_test.sv
`timescale 1ns/1ps
module atx_engine_test;
  localparam int AW = 16;
  localparam int DW = 64;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req_valid = 1'b0;
  logic          req_ready;
  logic [1:0]    req_op = '0;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_reg = '0;
  logic [DW-1:0] req_acc = '0;
  logic          busy, mem_req, mem_we, mem_lock, done;
  logic [AW-1:0] mem_addr;
  logic [DW-1:0] mem_wdata, res_reg, res_acc;
  logic          mem_ack = 1'b0;
  logic          mem_rvalid = 1'b0;
  logic [DW-1:0] mem_rdata = '0;
  logic [4:0]    res_flags;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  atx_engine #(.AW(AW), .DW(DW)) uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_op(req_op), .req_addr(req_addr), .req_reg(req_reg), .req_acc(req_acc),
    .busy(busy), .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rvalid(mem_rvalid),
    .mem_rdata(mem_rdata), .mem_lock(mem_lock), .done(done),
    .res_reg(res_reg), .res_acc(res_acc), .res_flags(res_flags)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // ---------------- memory model ----------------
  logic [DW-1:0] mem_arr [16];
  int ack_lat = 0;
  int rd_lat  = 0;
  int rd_seen = 0;
  int wr_seen = 0;

  initial begin
    bit r_hs, w_hs, pend;
    int ack_cnt, pend_cnt;
    logic [3:0] pend_idx;
    pend = 0; ack_cnt = 0; pend_cnt = 0; pend_idx = '0;
    forever begin
      @(negedge clk);
      r_hs = mem_req && mem_ack && !mem_we;
      w_hs = mem_req && mem_ack && mem_we;
      if (r_hs) begin pend = 1; pend_cnt = rd_lat; pend_idx = mem_addr[3:0]; end
      @(posedge clk); #2;
      if (w_hs) mem_arr[pend_idx] = mem_wdata;
      mem_ack = 1'b0;
      mem_rvalid = 1'b0;
      if (pend && !r_hs) begin
        if (pend_cnt == 0) begin
          mem_rvalid = 1'b1;
          mem_rdata  = mem_arr[pend_idx];
          pend = 0;
        end else pend_cnt--;
      end
      if (mem_req && !(r_hs || w_hs)) begin
        if (ack_cnt >= ack_lat) begin mem_ack = 1'b1; ack_cnt = 0; end
        else ack_cnt++;
      end
    end
  end

  // ---------------- reference model ----------------
  int            phase = 0;          // 0 idle, 1 read, 2 wait, 3 write, 4 done
  logic [1:0]    m_op;
  logic [AW-1:0] m_addr;
  logic [63:0]   m_reg, m_acc;
  logic [63:0]   e_w, e_reg, e_acc;
  logic [4:0]    e_flags;

  function automatic bit par_even(input logic [7:0] v);
    return ($countones(v) % 2) == 0;
  endfunction

  task automatic predict(input logic [63:0] m);
    logic [31:0] r32, a32, m32, s32;
    longint sl;
    bit c, ov;
    r32 = m_reg[31:0]; a32 = m_acc[31:0]; m32 = m[31:0];
    e_w = m; e_reg = m_reg; e_acc = m_acc; e_flags = '0;
    case (m_op)
      2'd0: begin
        e_w   = {m[63:32], r32};
        e_reg = {m_reg[63:32], m32};
      end
      2'd1: begin
        s32 = m32 + r32;
        c   = (longint'(m32) + longint'(r32)) > 64'sd4294967295;
        sl  = longint'($signed(m32)) + longint'($signed(r32));
        ov  = (sl > 64'sd2147483647) || (sl < -64'sd2147483648);
        e_w   = {m[63:32], s32};
        e_reg = {m_reg[63:32], m32};
        e_flags = {ov, s32[31], s32 == 0, par_even(s32[7:0]), c};
      end
      2'd2: begin
        s32 = a32 - m32;
        c   = a32 < m32;
        sl  = longint'($signed(a32)) - longint'($signed(m32));
        ov  = (sl > 64'sd2147483647) || (sl < -64'sd2147483648);
        e_flags = {ov, s32[31], a32 == m32, par_even(s32[7:0]), c};
        if (a32 == m32) e_w = {m[63:32], r32};
        else            e_acc = {m_acc[63:32], m32};
      end
      default: begin
        e_flags = {2'b00, m_acc == m, 2'b00};
        if (m_acc == m) e_w = m_reg;
        else            e_acc = m;
      end
    endcase
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      check(req_ready == (phase == 0), "R1", "req_ready", {63'b0, req_ready}, {63'b0, phase == 0});
      check(busy == (phase != 0), "R1", "busy", {63'b0, busy}, {63'b0, phase != 0});
      check(mem_lock == (phase >= 1 && phase <= 3), "R3", "mem_lock", {63'b0, mem_lock},
            {63'b0, phase >= 1 && phase <= 3});
      check(mem_req == (phase == 1 || phase == 3), "R2", "mem_req", {63'b0, mem_req},
            {63'b0, phase == 1 || phase == 3});
      check(done == (phase == 4), "R4", "done", {63'b0, done}, {63'b0, phase == 4});
      if (mem_req) check(mem_we == (phase == 3), "R2", "mem_we", {63'b0, mem_we}, {63'b0, phase == 3});
      case (phase)
        0: if (req_valid) begin
             m_op = req_op; m_addr = req_addr; m_reg = req_reg; m_acc = req_acc;
             phase = 1;
           end
        1: if (mem_ack) begin
             rd_seen++;
             check(mem_addr == m_addr, "R2", "read address", 64'(mem_addr), 64'(m_addr));
             predict(mem_arr[m_addr[3:0]]);
             phase = 2;
           end
        2: if (mem_rvalid) phase = 3;
        3: if (mem_ack) begin
             wr_seen++;
             check(mem_addr == m_addr, "R2", "write address", 64'(mem_addr), 64'(m_addr));
             check(mem_wdata == e_w, "R5-R11 op", "write data", mem_wdata, e_w);
             phase = 4;
           end
        default: begin
          check(res_reg == e_reg, "R5/R6/R11", "res_reg", res_reg, e_reg);
          check(res_acc == e_acc, "R7/R8/R10", "res_acc", res_acc, e_acc);
          check(res_flags == e_flags, "R6/R9/R10", "res_flags", 64'(res_flags), 64'(e_flags));
          check(rd_seen == 1 && wr_seen == 1, "R2", "one read one write",
                64'(rd_seen * 16 + wr_seen), 64'h11);
          rd_seen = 0; wr_seen = 0;
          phase = 0;
        end
      endcase
    end
  end

  // ---------------- stimulus ----------------
  task automatic issue(input logic [1:0] op, input logic [AW-1:0] a,
                       input logic [63:0] r, input logic [63:0] acc);
    @(posedge clk); #2;
    req_valid = 1'b1; req_op = op; req_addr = a; req_reg = r; req_acc = acc;
    forever begin
      @(negedge clk);
      if (req_ready) break;
    end
    @(posedge clk); #2;
    req_valid = 1'b0;
  endtask

  task automatic wait_done();
    for (int i = 0; i < 200; i++) begin
      @(negedge clk);
      if (done) return;
    end
    check(1'b0, "R4", "done timeout", 64'd0, 64'd1);
  endtask

  task automatic run(input logic [1:0] op, input logic [3:0] a, input logic [63:0] m,
                     input logic [63:0] r, input logic [63:0] acc);
    mem_arr[a] = m;
    issue(op, {12'h0, a}, r, acc);
    wait_done();
  endtask

  initial begin
    for (int i = 0; i < 16; i++) mem_arr[i] = {32'hA5A5_0000 + i, 32'h0000_1000 * i};
    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(req_ready && !busy && !mem_lock && !mem_req && !done, "R1", "reset state",
          {59'b0, req_ready, busy, mem_lock, mem_req, done}, 64'h10);

    // R5 swap
    run(2'd0, 4'd1, 64'hAAAA_BBBB_1111_2222, 64'h5555_6666_3333_4444, 64'h0123_4567_89AB_CDEF);
    // R6 fetch-add with carry out and zero result
    run(2'd1, 4'd2, 64'hDEAD_BEEF_FFFF_FFFF, 64'h0000_0007_0000_0001, 64'h0);
    // R6 fetch-add with signed overflow
    ack_lat = 2; rd_lat = 3;
    run(2'd1, 4'd3, 64'h1234_5678_7FFF_FFFF, 64'h0000_0000_0000_0001, 64'h0);
    // R7 R9 compare-swap match
    run(2'd2, 4'd4, 64'hCAFE_F00D_0000_0042, 64'h9999_8888_7777_6666, 64'hBEEF_0000_0000_0042);
    // R8 R9 compare-swap mismatch with borrow
    ack_lat = 1; rd_lat = 0;
    run(2'd2, 4'd5, 64'h1111_2222_0000_0010, 64'h3333_4444_5555_6666, 64'h7777_8888_0000_0003);
    // R9 signed overflow on the subtraction
    run(2'd2, 4'd6, 64'h0000_0001_0000_0001, 64'h0, 64'hFFFF_0000_8000_0000);
    // R10 wide compare match and mismatch
    run(2'd3, 4'd7, 64'h0102_0304_0506_0708, 64'hF0F0_E1E1_D2D2_C3C3, 64'h0102_0304_0506_0708);
    ack_lat = 3; rd_lat = 2;
    run(2'd3, 4'd8, 64'h0102_0304_0506_0708, 64'hF0F0_E1E1_D2D2_C3C3, 64'h0102_0304_0506_0709);
    // R11 upper half kept by memory after a 32-bit op
    check(mem_arr[1][63:32] == 32'hAAAA_BBBB, "R11", "memory upper half", 64'(mem_arr[1][63:32]),
          64'hAAAA_BBBB);
    check(mem_arr[5] == 64'h1111_2222_0000_0010, "R8", "word unchanged after mismatch", mem_arr[5],
          64'h1111_2222_0000_0010);
    // R1 back-to-back: second request waits while busy
    ack_lat = 0; rd_lat = 1;
    issue(2'd1, 16'd9, 64'h0000_0000_0000_0005, 64'h0);
    issue(2'd1, 16'd9, 64'h0000_0000_0000_0005, 64'h0);
    wait_done();
    check(mem_arr[9][31:0] == 32'h0000_900A, "R6", "two adds applied", 64'(mem_arr[9][31:0]),
          64'h900A);
    repeat (3) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual hung expected finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule